// File: doc/BRIEF.md
# Serial Shift-Register Controller for a Switched-Capacitor Sampler

This block sits between a system-clocked request interface and the control pins of a switched-capacitor waveform sampling chip. The chip holds two 8-bit serial registers. One is a configuration register. The other is a write-shift ring that the running sampling wave rotates each time it crosses a segment boundary. A request selects one of three operations: load the configuration register, load the write-shift ring, or read back the stop segment after a trigger. The block then drives the chip's 4-bit address bus, serial clock, serial data and write-enable pins in the right order, and raises a one-cycle completion pulse at the end.

The chip has no shadow copy of the ring, so a boundary crossing during a serial load would corrupt the loaded value. To prevent this, the block holds write-enable low for the whole of every operation. In the cascaded two-segment mode the ring is loaded with 0x55. After a stop it holds either 0x55 or 0xAA. The block decides which segment held the stop from the single bit that appears on the chip's dedicated ring-output pin. Sampling-enable is never dropped.

Top module: `sampler_sreg_ctrl`

## Requirements
- R1: Out of reset and whenever no operation is in progress, the address bus reads 1111, the serial clock is low, busy and done are low, and write-enable is high while the stop input is low.
- R2: The sampling-enable output is high in every cycle.
- R3: Write-enable is low in every cycle in which busy is high. It returns high, together with address 1111, in the same cycle that done pulses, which is one cycle after the falling edge of the last serial clock pulse.
- R4: The target address is driven at least one full cycle before the first rising edge of the serial clock, and it does not change while a serial clock pulse is in progress.
- R5: Op code 1 loads the write-shift ring at address 1101. It gives exactly 8 serial clock pulses, each low for HALF_PER cycles and then high for HALF_PER cycles. Data goes out most significant bit first and is valid across each rising edge. Accept to done takes 16*HALF_PER+2 cycles.
- R6: Op code 0 loads the configuration register in the same way at address 1100, and leaves the write-shift ring untouched.
- R7: Op code 2 drives address 1101 with no serial clock pulses. It samples the ring-output pin RD_DLY+1 cycles after the address appears and reports that bit on the segment output with done. A value of 1 means the ring holds 0xAA, the second segment; a value of 0 means 0x55, the first segment. Accept to done takes RD_DLY+1 cycles.
- R8: A request that arrives while busy is high is ignored. It causes no extra done pulse and no serial clock pulse to another register.
- R9: While the stop input is high and no operation runs, write-enable is low from the next cycle on. It returns high in the cycle after the stop input falls.
- R10: Op code 3 is reserved and is ignored: busy stays low and no done pulse follows.
- R11: Done is a single-cycle pulse, exactly one for each accepted operation, and busy is high from the cycle after acceptance until done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, sampled while idle |
| req_op_i | input | 2 | 0 config load, 1 ring load, 2 segment read, 3 reserved |
| req_data_i | input | DW | Value to load |
| trig_stop_i | input | 1 | Trigger stop; holds write-enable low while high |
| wsr_pin_i | input | 1 | Chip's dedicated ring-output pin |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| seg_o | output | 1 | Stop segment from the last read |
| addr_o | output | 4 | Chip address bus |
| sclk_o | output | 1 | Serial clock to the chip |
| sdata_o | output | 1 | Serial data to the chip |
| wr_en_o | output | 1 | Chip write-enable |
| samp_en_o | output | 1 | Chip sampling-enable |

## Verification
The bench builds the block with HALF_PER=2 and RD_DLY=3. With a multi-cycle serial clock, a request can be inserted in the middle of a pulse, and a boundary event can be raised while the clock is high. A readback delay of several cycles separates the read latency clearly from the address setup. A bench model of the chip rotates its ring on boundary events whenever write-enable is high. The bench checks that a boundary fired during a load leaves 0x55 intact, and that rotations made in idle flip the decoded segment between 1 and 0.

// File: rtl/sampler_sreg_pkg.sv
package sampler_sreg_pkg;

    typedef enum logic [1:0] {
        OP_CFG = 2'd0,
        OP_WSR = 2'd1,
        OP_SEG = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    localparam logic [3:0] A_IDLE = 4'b1111;
    localparam logic [3:0] A_CFG  = 4'b1100;
    localparam logic [3:0] A_WSR  = 4'b1101;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_LOW,
        S_HIGH,
        S_FINISH,
        S_WAIT
    } st_e;

    typedef struct packed {
        st_e        st;
        logic [3:0] addr;
        logic       sclk;
        logic       we;
        logic       done;
        logic       seg;
        logic       rd;
    } ctl_t;

endpackage

// File: rtl/sreg_phase_timer.sv
module sreg_phase_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (ld)
            cnt_d = ld_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sreg_serializer.sv
module sreg_serializer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [DW-1:0] ld_data,
    input  logic          adv,
    output logic          bit_o,
    output logic          last_o
);
    localparam int IW = $clog2(DW);

    logic [DW-1:0] sh_d, sh_q;
    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        sh_d  = sh_q;
        idx_d = idx_q;
        if (ld) begin
            sh_d  = ld_data;
            idx_d = '0;
        end else if (adv) begin
            sh_d  = {sh_q[DW-2:0], 1'b0};
            idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else begin
            sh_q  <= sh_d;
            idx_q <= idx_d;
        end
    end

    assign bit_o  = sh_q[DW-1];
    assign last_o = (idx_q == IW'(DW-1));
endmodule

// File: rtl/sampler_sreg_ctrl.sv
module sampler_sreg_ctrl
    import sampler_sreg_pkg::*;
#(
    parameter int DW       = 8,
    parameter int HALF_PER = 1,
    parameter int RD_DLY   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic [1:0]    req_op_i,
    input  logic [DW-1:0] req_data_i,
    input  logic          trig_stop_i,
    input  logic          wsr_pin_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          seg_o,
    output logic [3:0]    addr_o,
    output logic          sclk_o,
    output logic          sdata_o,
    output logic          wr_en_o,
    output logic          samp_en_o
);
    localparam int TMAX = (HALF_PER > RD_DLY) ? HALF_PER : RD_DLY;
    localparam int TW   = $clog2(TMAX) + 1;
    localparam logic [TW-1:0] T_HALF = TW'(HALF_PER - 1);
    localparam logic [TW-1:0] T_RD   = TW'(RD_DLY - 1);

    ctl_t q, d;

    logic          tmr_ld;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          ser_ld;
    logic          ser_adv;
    logic          ser_bit;
    logic          ser_last;
    op_e           op;

    assign op = op_e'(req_op_i);

    sreg_phase_timer #(.W(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (tmr_ld),
        .ld_val (tmr_val),
        .zero   (tmr_zero)
    );

    sreg_serializer #(.DW(DW)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (ser_ld),
        .ld_data (req_data_i),
        .adv     (ser_adv),
        .bit_o   (ser_bit),
        .last_o  (ser_last)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        ser_ld  = 1'b0;
        ser_adv = 1'b0;
        case (q.st)
            S_IDLE: begin
                d.we   = !trig_stop_i;
                d.addr = A_IDLE;
                d.sclk = 1'b0;
                if (req_valid_i && op != OP_RSV) begin
                    d.st   = S_SETUP;
                    d.we   = 1'b0;
                    d.addr = (op == OP_CFG) ? A_CFG : A_WSR;
                    d.rd   = (op == OP_SEG);
                    ser_ld = (op != OP_SEG);
                end
            end
            S_SETUP: begin
                tmr_ld = 1'b1;
                if (q.rd) begin
                    d.st    = S_WAIT;
                    tmr_val = T_RD;
                end else begin
                    d.st    = S_LOW;
                    tmr_val = T_HALF;
                end
            end
            S_LOW: begin
                if (tmr_zero) begin
                    d.st    = S_HIGH;
                    d.sclk  = 1'b1;
                    tmr_ld  = 1'b1;
                    tmr_val = T_HALF;
                end
            end
            S_HIGH: begin
                if (tmr_zero) begin
                    d.sclk  = 1'b0;
                    ser_adv = 1'b1;
                    if (ser_last) begin
                        d.st = S_FINISH;
                    end else begin
                        d.st    = S_LOW;
                        tmr_ld  = 1'b1;
                        tmr_val = T_HALF;
                    end
                end
            end
            S_FINISH: begin
                d.st   = S_IDLE;
                d.we   = !trig_stop_i;
                d.addr = A_IDLE;
                d.done = 1'b1;
            end
            S_WAIT: begin
                if (tmr_zero) begin
                    d.st   = S_IDLE;
                    d.seg  = wsr_pin_i;
                    d.we   = !trig_stop_i;
                    d.addr = A_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.addr <= A_IDLE;
            q.sclk <= 1'b0;
            q.we   <= 1'b1;
            q.done <= 1'b0;
            q.seg  <= 1'b0;
            q.rd   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st != S_IDLE);
    assign done_o    = q.done;
    assign seg_o     = q.seg;
    assign addr_o    = q.addr;
    assign sclk_o    = q.sclk;
    assign sdata_o   = ser_bit;
    assign wr_en_o   = q.we;
    assign samp_en_o = 1'b1;
endmodule

// File: rtl/sampler_sreg_chk.sv
module sampler_sreg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic [3:0] addr_o,
    input logic       sclk_o,
    input logic       wr_en_o
);
    assert_idle_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (addr_o == 4'b1111 && !sclk_o));

    assert_busy_we_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !wr_en_o);

    assert_sclk_we_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !wr_en_o);

    assert_addr_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> ($stable(addr_o) && addr_o != 4'b1111));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(addr_o));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));
endmodule

bind sampler_sreg_ctrl sampler_sreg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .addr_o  (addr_o),
    .sclk_o  (sclk_o),
    .wr_en_o (wr_en_o)
);

// File: tb/sim_sampler_sreg_ctrl.sv
`timescale 1ns/1ps
module sim_sampler_sreg_ctrl;
    localparam int H  = 2;
    localparam int RD = 3;
    localparam int WR_LAT = 16*H + 2;
    localparam int RD_LAT = RD + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [7:0] req_data = 8'h00;
    logic       trig = 1'b0;
    logic       bnd = 1'b0;
    logic       busy_o, done_o, seg_o, sclk_o, sdata_o, wr_en_o, samp_en_o;
    logic [3:0] addr_o;

    logic [7:0] m_wsr = 8'hFF;
    logic [7:0] m_cfg = 8'h00;
    logic       sclk_prev = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sampler_sreg_ctrl #(.DW(8), .HALF_PER(H), .RD_DLY(RD)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
        .req_data_i(req_data), .trig_stop_i(trig), .wsr_pin_i(m_wsr[7]),
        .busy_o(busy_o), .done_o(done_o), .seg_o(seg_o), .addr_o(addr_o),
        .sclk_o(sclk_o), .sdata_o(sdata_o), .wr_en_o(wr_en_o), .samp_en_o(samp_en_o)
    );

    // chip model: shift in on serial clock rise, rotate on boundary when write-enabled
    always @(posedge clk) begin
        if (sclk_o && !sclk_prev) begin
            if (addr_o == 4'b1101)      m_wsr <= {m_wsr[6:0], sdata_o};
            else if (addr_o == 4'b1100) m_cfg <= {m_cfg[6:0], sdata_o};
        end else if (bnd && wr_en_o) begin
            m_wsr <= {m_wsr[6:0], m_wsr[7]};
        end
        sclk_prev <= sclk_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [7:0] dv, input logic [3:0] ea,
                         input bit intrude, output int lat, output int pulses,
                         output bit we_bad, output bit addr_bad);
        bit pv = 1'b0;
        lat = 0; pulses = 0; we_bad = 0; addr_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = dv;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done_o && lat < 2000) begin
            if (busy_o) begin
                if (wr_en_o) we_bad = 1;
                if (addr_o != ea) addr_bad = 1;
                if (sclk_o && !pv) pulses++;
            end
            pv = sclk_o;
            if (intrude && lat == 5) begin
                req_valid = 1'b1; req_op = 2'd0; req_data = 8'hFF;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
    endtask

    task automatic pulse_bnd();
        @(negedge clk); bnd = 1'b1;
        @(negedge clk); bnd = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(addr_o == 4'hF && !sclk_o && !busy_o && !done_o && wr_en_o, "R1 reset idle",
            {addr_o, sclk_o, busy_o, done_o, wr_en_o}, 8'hF1);
        chk(samp_en_o == 1'b1, "R2 sampling enable", samp_en_o, 1);
    endtask

    task automatic t_wsr_load();
        int lat, p; bit wb, ab;
        do_op(2'd1, 8'hC5, 4'hD, 0, lat, p, wb, ab);
        chk(lat == WR_LAT, "R5/R11 ring load latency", lat, WR_LAT);
        chk(p == 8, "R5 pulse count", p, 8);
        chk(m_wsr == 8'hC5, "R5 ring value msb first", m_wsr, 8'hC5);
        chk(!wb, "R3 we low during load", wb, 0);
        chk(!ab, "R4 address held 1101", ab, 0);
        chk(wr_en_o && addr_o == 4'hF, "R3 restore with done", {wr_en_o, addr_o}, 5'h1F);
        @(negedge clk);
        chk(!done_o, "R11 done single cycle", done_o, 0);
        chk(samp_en_o == 1'b1, "R2 sampling enable after load", samp_en_o, 1);
    endtask

    task automatic t_cfg_load();
        int lat, p; bit wb, ab;
        logic [7:0] w0 = m_wsr;
        do_op(2'd0, 8'h5A, 4'hC, 0, lat, p, wb, ab);
        chk(m_cfg == 8'h5A, "R6 config value", m_cfg, 8'h5A);
        chk(m_wsr == w0, "R6 ring untouched", m_wsr, w0);
        chk(lat == WR_LAT && p == 8 && !ab && !wb, "R6 config timing", lat, WR_LAT);
    endtask

    task automatic t_busy_ignore();
        int lat, p, extra = 0; bit wb, ab;
        logic [7:0] c0 = m_cfg;
        do_op(2'd1, 8'h96, 4'hD, 1, lat, p, wb, ab);
        chk(lat == WR_LAT && p == 8, "R8 first op unaffected", lat, WR_LAT);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done_o || busy_o) extra++;
        end
        chk(extra == 0, "R8 no second op", extra, 0);
        chk(m_cfg == c0, "R8 config untouched", m_cfg, c0);
        chk(m_wsr == 8'h96, "R8 ring value", m_wsr, 8'h96);
    endtask

    task automatic t_reserved();
        int act = 0;
        @(negedge clk); req_valid = 1'b1; req_op = 2'd3; req_data = 8'h00;
        @(negedge clk); req_valid = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (busy_o || done_o || sclk_o) act++;
            @(negedge clk);
        end
        chk(act == 0, "R10 reserved op ignored", act, 0);
    endtask

    task automatic t_segment();
        int lat, p; bit wb, ab;
        do_op(2'd1, 8'h55, 4'hD, 0, lat, p, wb, ab);
        chk(m_wsr == 8'h55, "R5 cascade pattern loaded", m_wsr, 8'h55);
        // boundary during a load must be suppressed (write-enable low)
        fork
            do_op(2'd1, 8'h55, 4'hD, 0, lat, p, wb, ab);
            begin repeat (9) @(negedge clk); bnd = 1'b1; @(negedge clk); bnd = 1'b0; end
        join
        chk(m_wsr == 8'h55, "R3 boundary during load suppressed", m_wsr, 8'h55);
        pulse_bnd();
        chk(m_wsr == 8'hAA, "R3 boundary in idle rotates", m_wsr, 8'hAA);
        @(negedge clk); trig = 1'b1;
        @(negedge clk);
        chk(!wr_en_o, "R9 stop drops write-enable", wr_en_o, 0);
        pulse_bnd();
        chk(m_wsr == 8'hAA, "R9 boundary while stopped ignored", m_wsr, 8'hAA);
        do_op(2'd2, 8'h00, 4'hD, 0, lat, p, wb, ab);
        chk(lat == RD_LAT, "R7 read latency", lat, RD_LAT);
        chk(p == 0, "R7 no serial pulses", p, 0);
        chk(seg_o == 1'b1, "R7 segment 1 for AA", seg_o, 1);
        chk(!wr_en_o, "R9 we low after read while stopped", wr_en_o, 0);
        trig = 1'b0;
        @(negedge clk);
        chk(wr_en_o, "R9 release restores write-enable", wr_en_o, 1);
        pulse_bnd();
        do_op(2'd2, 8'h00, 4'hD, 0, lat, p, wb, ab);
        chk(seg_o == 1'b0 && !wb && !ab, "R7 segment 0 for 55", seg_o, 0);
        do_op(2'd1, 8'hFF, 4'hD, 0, lat, p, wb, ab);
        pulse_bnd();
        do_op(2'd2, 8'h00, 4'hD, 0, lat, p, wb, ab);
        chk(seg_o == 1'b1 && m_wsr == 8'hFF, "R7 all ones mode", {seg_o, m_wsr}, 9'h1FF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wsr_load();
        t_cfg_load();
        t_busy_ignore();
        t_reserved();
        t_segment();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule